// File: doc/BRIEF.md
# Stack Pointer Unit with Configurable Reset-Stack Command

This block keeps the stack pointer of a small CPU. Push and pop strobes move the pointer down and up by one. A reset-stack command strobe (here called the stack command) acts in one of two ways, and a build-time parameter picks the way. In the fixed form, the command returns the pointer to its start address. In the movable form, a general-purpose flag selects the action. With the flag set, the command loads the pointer from a register pair. With the flag clear, it copies the pointer out to that register pair through a one-cycle write-back strobe.

A second parameter turns on a supervisor restriction. The stack command then acts only while the interrupt-enable bit is set. Under this restriction the interrupt-enable bit must come out of reset set, and the block reports that reset value to the flag logic on a dedicated output. Instruction decode, memory accesses and the register file are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted and after its release, the pointer equals `START_ADDR` (default 16'h03FF) and `wbValid` is 0.
- R2: A push without pop or command decrements the pointer by one on the next clock edge, wrapping from 16'h0000 to 16'hFFFF.
- R3: A pop without push or command increments the pointer by one on the next clock edge, wrapping from 16'hFFFF to 16'h0000.
- R4: With push and pop both asserted, or neither asserted, and no command, the pointer holds its value.
- R5: With `ALLOW_MOVE`=0, an accepted stack command sets the pointer to `START_ADDR`, whatever the flag, and never raises `wbValid`.
- R6: With `ALLOW_MOVE`=1 and `gpFlag`=1, an accepted command loads the pointer with {`pairHi`,`pairLo`} on the next edge, and `wbValid` stays 0.
- R7: With `ALLOW_MOVE`=1 and `gpFlag`=0, an accepted command leaves the pointer unchanged. It raises `wbValid` for exactly the one cycle after the command, with `wbData` equal to the pointer as it was in the command cycle.
- R8: In a cycle with the stack command asserted, push and pop are ignored.
- R9: With `SUPERVISOR`=1 and `iBit`=0, a stack command has no effect: the pointer holds, `wbValid` stays 0, and any push or pop in that cycle is also ignored.
- R10: `iBitInit` is 1 when `SUPERVISOR`=1 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushStb | input | 1 | Push strobe |
| popStb | input | 1 | Pop strobe |
| rspStb | input | 1 | Stack command strobe |
| pairHi | input | ADDR_W/2 | High byte of register pair |
| pairLo | input | ADDR_W/2 | Low byte of register pair |
| gpFlag | input | 1 | General-purpose flag selecting load (1) or copy-out (0) |
| iBit | input | 1 | Interrupt-enable bit |
| sp | output | ADDR_W | Current stack pointer |
| wbData | output | ADDR_W | Pointer value to write to the register pair |
| wbValid | output | 1 | One-cycle write-back strobe |
| iBitInit | output | 1 | Reset value for the interrupt-enable bit |

## Verification
Assertions check on every cycle that push and pop change the pointer by exactly one, and that an idle or cancelled cycle leaves it stable. They also check that reset and load commands land their values, that at most one action is decoded per cycle, and that the write-back strobe follows only a copy-out command that was permitted. Some behaviours only the bench's scenarios can show: the wrap-around at both ends of the address space, and the agreement of both parameter variants with an independent model over long random sequences. The bench also shows the reported reset value of the interrupt-enable bit.

// File: rtl/spu_pkg.sv
package spu_pkg;
  // One action per cycle; control drives, datapath consumes.
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doReset;
    logic doLoad;
    logic doCopy;
  } spuCmd_t;
endpackage

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
#(
  parameter bit ALLOW_MOVE = 1'b0,
  parameter bit SUPERVISOR = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pushStb,
  input  logic    popStb,
  input  logic    rspStb,
  input  logic    gpFlag,
  input  logic    iBit,
  output spuCmd_t cmd,
  output logic    wbValid
);
  logic rspOk;
  logic moveLoad;
  logic moveCopy;
  logic fixedReset;
  logic stackQuiet;

  // Supervisor gate: command accepted only with interrupts enabled
  assign rspOk      = rspStb && (!SUPERVISOR || iBit);
  assign stackQuiet = !rspStb && (pushStb != popStb);

  generate
    if (ALLOW_MOVE) begin : g_move
      assign moveLoad   = rspOk && gpFlag;
      assign moveCopy   = rspOk && !gpFlag;
      assign fixedReset = 1'b0;
    end else begin : g_fixed
      assign moveLoad   = 1'b0;
      assign moveCopy   = 1'b0;
      assign fixedReset = rspOk;
    end
  endgenerate

  always_comb begin
    cmd         = '0;
    cmd.doPush  = stackQuiet && pushStb;
    cmd.doPop   = stackQuiet && popStb;
    cmd.doReset = fixedReset;
    cmd.doLoad  = moveLoad;
    cmd.doCopy  = moveCopy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wbValid <= 1'b0;
    else       wbValid <= cmd.doCopy;
  end

  // R8
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));

  // R7
  wb_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ($past(rspStb) && !$past(gpFlag) && ALLOW_MOVE));

  // R9
  sup_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (SUPERVISOR && rspStb && !iBit) |=> !wbValid);

  // R8
  rsp_blocks_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspStb |-> (!cmd.doPush && !cmd.doPop));
endmodule

// File: rtl/spu_datapath.sv
module spu_datapath
  import spu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h03FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  spuCmd_t           cmd,
  input  logic [ADDR_W-1:0] loadVal,
  output logic [ADDR_W-1:0] spReg,
  output logic [ADDR_W-1:0] wbData
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] spNext;

  always_comb begin
    spNext = spReg;
    unique case (1'b1)
      cmd.doPush:  spNext = spReg - ONE;
      cmd.doPop:   spNext = spReg + ONE;
      cmd.doReset: spNext = START_ADDR;
      cmd.doLoad:  spNext = loadVal;
      default:     spNext = spReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spReg  <= START_ADDR;
      wbData <= '0;
    end else begin
      spReg <= spNext;
      if (cmd.doCopy) wbData <= spReg;
    end
  end

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doPush |=> spReg == $past(spReg) - ONE);

  // R3
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doPop |=> spReg == $past(spReg) + ONE);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == '0) |=> $stable(spReg));

  // R5
  reset_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doReset |=> spReg == START_ADDR);

  // R6
  load_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doLoad |=> spReg == $past(loadVal));

  // R7
  copy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doCopy |=> ($stable(spReg) && wbData == spReg));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h03FF,
  parameter bit ALLOW_MOVE = 1'b0,
  parameter bit SUPERVISOR = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushStb,
  input  logic                popStb,
  input  logic                rspStb,
  input  logic [ADDR_W/2-1:0] pairHi,
  input  logic [ADDR_W/2-1:0] pairLo,
  input  logic                gpFlag,
  input  logic                iBit,
  output logic [ADDR_W-1:0]   sp,
  output logic [ADDR_W-1:0]   wbData,
  output logic                wbValid,
  output logic                iBitInit
);
  spuCmd_t cmd;
  logic [ADDR_W-1:0] pairVal;

  assign pairVal  = {pairHi, pairLo};
  assign iBitInit = SUPERVISOR;

  spu_ctrl #(
    .ALLOW_MOVE(ALLOW_MOVE),
    .SUPERVISOR(SUPERVISOR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .pushStb(pushStb), .popStb(popStb),
    .rspStb(rspStb), .gpFlag(gpFlag), .iBit(iBit),
    .cmd(cmd), .wbValid(wbValid)
  );

  spu_datapath #(
    .ADDR_W(ADDR_W),
    .START_ADDR(START_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(pairVal),
    .spReg(sp), .wbData(wbData)
  );

  // R1
  reset_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !wbValid);
endmodule

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;
  localparam logic [15:0] START = 16'h03FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushStb = 0, popStb = 0, rspStb = 0, gpFlag = 0, iBit = 0;
  logic [7:0] pairHi = 0, pairLo = 0;
  logic [15:0] sp1, wbd1, sp2, wbd2;
  logic wbv1, wbv2, ib1, ib2;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] e1Sp, e2Sp, e2Wd;
  bit e2Wb;

  always #5 clk = ~clk;

  // fixed-form, no supervisor
  stack_ptr_unit dut_i (
    .clk(clk), .rstN(rstN), .pushStb(pushStb), .popStb(popStb),
    .rspStb(rspStb), .pairHi(pairHi), .pairLo(pairLo), .gpFlag(gpFlag),
    .iBit(iBit), .sp(sp1), .wbData(wbd1), .wbValid(wbv1), .iBitInit(ib1)
  );

  // movable form with supervisor gate
  stack_ptr_unit #(.ALLOW_MOVE(1'b1), .SUPERVISOR(1'b1)) dut_mv_i (
    .clk(clk), .rstN(rstN), .pushStb(pushStb), .popStb(popStb),
    .rspStb(rspStb), .pairHi(pairHi), .pairLo(pairLo), .gpFlag(gpFlag),
    .iBit(iBit), .sp(sp2), .wbData(wbd2), .wbValid(wbv2), .iBitInit(ib2)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string stackTag(bit pu, bit po);
    if (pu && !po) return "R2";
    if (po && !pu) return "R3";
    return "R4";
  endfunction

  function automatic logic [15:0] stackMove(logic [15:0] cur, bit pu, bit po);
    if (pu && !po) return cur - 16'd1;
    if (po && !pu) return cur + 16'd1;
    return cur;
  endfunction

  task automatic step(input bit pu, input bit po, input bit rs,
                      input logic [7:0] hi, input logic [7:0] lo,
                      input bit gp, input bit ib);
    string t1, t2;
    pushStb = pu; popStb = po; rspStb = rs;
    pairHi = hi; pairLo = lo; gpFlag = gp; iBit = ib;
    // fixed-form model
    if (rs) begin
      e1Sp = START;
      t1 = (pu || po) ? "R8" : "R5";
    end else begin
      e1Sp = stackMove(e1Sp, pu, po);
      t1 = stackTag(pu, po);
    end
    // movable supervisor model
    e2Wb = 1'b0;
    if (rs) begin
      if (!ib) t2 = "R9";
      else begin
        t2 = (pu || po) ? "R8" : (gp ? "R6" : "R7");
        if (gp) e2Sp = {hi, lo};
        else begin
          e2Wb = 1'b1;
          e2Wd = e2Sp;
        end
      end
    end else begin
      e2Sp = stackMove(e2Sp, pu, po);
      t2 = stackTag(pu, po);
    end
    @(negedge clk);
    check(sp1 == e1Sp, t1, "fixed sp", sp1, e1Sp);
    check(wbv1 == 1'b0, t1, "fixed wbValid", wbv1, 0);
    check(sp2 == e2Sp, t2, "move sp", sp2, e2Sp);
    check(wbv2 == e2Wb, t2, "move wbValid", wbv2, e2Wb);
    if (e2Wb) check(wbd2 == e2Wd, "R7", "move wbData", wbd2, e2Wd);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state, R10 interrupt-enable reset value
    check(sp1 == START, "R1", "fixed sp in reset", sp1, START);
    check(sp2 == START, "R1", "move sp in reset", sp2, START);
    check(wbv1 == 0 && wbv2 == 0, "R1", "wbValid in reset", {wbv1, wbv2}, 0);
    check(ib1 == 1'b0, "R10", "fixed iBitInit", ib1, 0);
    check(ib2 == 1'b1, "R10", "supervisor iBitInit", ib2, 1);
    rstN = 1'b1;
    e1Sp = START; e2Sp = START; e2Wd = 0; e2Wb = 0;
    @(negedge clk);
    check(sp1 == START && sp2 == START, "R1", "sp after release", sp1, START);

    // R2 wrap: 1024 pushes take 03FF through 0000 to FFFF
    for (int i = 0; i < 1024; i++) step(1, 0, 0, 8'h00, 8'h00, 0, 0);
    check(sp1 == 16'hFFFF, "R2", "push wrap", sp1, 16'hFFFF);
    // R3 wrap back
    step(0, 1, 0, 8'h00, 8'h00, 0, 0);
    check(sp1 == 16'h0000, "R3", "pop wrap", sp1, 16'h0000);
    // R4 both strobes
    step(1, 1, 0, 8'h00, 8'h00, 0, 0);
    // R5 fixed command ignores flag
    step(0, 0, 1, 8'h12, 8'h34, 1, 1);
    check(sp1 == START, "R5", "fixed command", sp1, START);
    // R6 load 0000, then push wraps
    step(0, 0, 1, 8'h00, 8'h00, 1, 1);
    step(1, 0, 0, 8'h00, 8'h00, 0, 1);
    check(sp2 == 16'hFFFF, "R2", "move push wrap", sp2, 16'hFFFF);
    // R7 copy-out, then strobe drops
    step(0, 0, 1, 8'hAA, 8'h55, 0, 1);
    step(0, 0, 0, 8'h00, 8'h00, 0, 1);
    check(wbv2 == 1'b0, "R7", "wbValid one cycle", wbv2, 0);
    // R9 blocked command with push
    step(1, 0, 1, 8'h77, 8'h66, 1, 0);
    step(0, 1, 1, 8'h77, 8'h66, 0, 0);
    // R8 command with pop
    step(0, 1, 1, 8'h80, 8'h01, 1, 1);
    check(sp2 == 16'h8001, "R8", "load wins over pop", sp2, 16'h8001);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 7) == 0),
           8'($urandom), 8'($urandom),
           $urandom_range(0, 1), $urandom_range(0, 3) != 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule